// File: doc/BRIEF.md
# System Clock Source Selector

This block picks which of four clock sources drives the system clock. The four are a multi-speed internal oscillator, a 16 MHz internal oscillator, an external oscillator and a PLL. Software writes the code of the source it wants. The block keeps the present selection until that source reports ready, and then commits the switch on one control-clock edge. A request for a source that is not ready stays pending and completes on its own once the source comes up. The committed code drives the select of a glitch-free clock mux, which lies outside this block, and the same code is also the active-source status.

Each oscillator and the PLL is modelled as a handshake: an enable goes out and a ready comes back. Software asks for enables through a per-source request vector. The block forces the enable on for the source in use. When the PLL is in use, it also forces on the oscillator that feeds the PLL. Per-source ready flags are reported, masked by the effective enables. After reset the multi-speed oscillator, at its 4 MHz default, is the system clock.

Top module: `sysclk_sel`

## Requirements
- R1: While reset is asserted and after it is released, `act_src_o` is 2'b00 (multi-speed internal), `pend_o` is 0 and `osc_en_o[0]` is 1. The source codes are 2'b00 multi-speed internal, 2'b01 16 MHz internal, 2'b10 external and 2'b11 PLL, and bit i of every per-source vector belongs to code i.
- R2: A write of a code that differs from `act_src_o` sets `pend_o` on that edge. On the next edge where the target's `rdy_o` bit is 1 and no write is present, `act_src_o` takes the target code and `pend_o` clears, both on that same edge.
- R3: While the target's `rdy_o` bit is 0, `act_src_o` holds and `pend_o` stays 1. The switch completes with no further write once the ready bit rises.
- R4: A write that arrives while a request is pending replaces the pending target. A write takes priority over a commit on the same edge.
- R5: A write of the code already in `act_src_o` clears `pend_o` and leaves `act_src_o` unchanged.
- R6: If the target's ready bit drops after the write but before the commit edge, no commit happens. The request waits for ready again.
- R7: `osc_en_o[act_src_o]` is 1 whatever `en_req_i` holds.
- R8: While `act_src_o` is 2'b11 and `pll_src_i` is 2'b00, 2'b01 or 2'b10, the enable bit that `pll_src_i` selects is forced to 1. A `pll_src_i` of 2'b11 means the PLL has no input, and no extra bit is forced.
- R9: An enable bit that is not protected under R7 or R8 equals the matching `en_req_i` bit.
- R10: `rdy_o[i]` equals `osc_rdy_i[i] & osc_en_o[i]`.
- R11: `act_src_o` changes only on an edge where a request was pending and its target's `rdy_o` bit was 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Control clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_we_i | input | 1 | Write strobe for a source request |
| req_src_i | input | 2 | Requested source code |
| pll_src_i | input | 2 | Oscillator that feeds the PLL (2'b11 = none) |
| en_req_i | input | 4 | Enables requested by software, one bit per source |
| osc_rdy_i | input | 4 | Ready from each oscillator and PLL lock |
| osc_en_o | output | 4 | Effective enables after protection |
| rdy_o | output | 4 | Ready flags masked by effective enable |
| act_src_o | output | 2 | Committed system clock source code (status) |
| pend_o | output | 1 | A switch request is waiting for ready |

## Verification
The assertions assume that `osc_rdy_i` and `pll_src_i` are synchronous to `clk_i`. They also assume that a ready rising during a pending request is meant to commit the request, even if the ready would drop again one cycle later. The stimulus drives every input on the falling edge, so each input is stable across the next rising edge. Ready bits are drawn with a bias that mixes long holds with short glitches, so pending, drop-before-commit and replace cases all occur. `pll_src_i` is free to change while the PLL is active, because the protection follows its live value.

// File: rtl/sysclk_sel_pkg.sv
package sysclk_sel_pkg;
  localparam int unsigned SRC_N = 4;
  localparam int unsigned SRC_W = $clog2(SRC_N);

  localparam logic [SRC_W-1:0] SRC_MULTI = 2'b00;
  localparam logic [SRC_W-1:0] SRC_INT16 = 2'b01;
  localparam logic [SRC_W-1:0] SRC_EXT   = 2'b10;
  localparam logic [SRC_W-1:0] SRC_PLL   = 2'b11;

  localparam logic [SRC_W-1:0] SRC_RESET = SRC_MULTI;
endpackage

// File: rtl/ssel_pend.sv
module ssel_pend
  import sysclk_sel_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_we_i,
  input  logic [SRC_W-1:0] req_src_i,
  input  logic [SRC_W-1:0] act_i,
  input  logic             commit_i,
  output logic             pend_o,
  output logic [SRC_W-1:0] tgt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= 1'b0;
      tgt_o  <= SRC_RESET;
    end else if (req_we_i) begin
      // a newer write always wins; asking for the active source cancels
      if (req_src_i == act_i) begin
        pend_o <= 1'b0;
      end else begin
        pend_o <= 1'b1;
        tgt_o  <= req_src_i;
      end
    end else if (commit_i) begin
      pend_o <= 1'b0;
    end
  end
endmodule

// File: rtl/ssel_commit.sv
module ssel_commit
  import sysclk_sel_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_we_i,
  input  logic             pend_i,
  input  logic [SRC_W-1:0] tgt_i,
  input  logic [SRC_N-1:0] rdy_i,
  output logic             commit_o,
  output logic [SRC_W-1:0] act_o
);
  assign commit_o = pend_i & rdy_i[tgt_i] & ~req_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       act_o <= SRC_RESET;
    else if (commit_o) act_o <= tgt_i;
  end
endmodule

// File: rtl/ssel_keep.sv
module ssel_keep
  import sysclk_sel_pkg::*;
(
  input  logic [SRC_W-1:0] act_i,
  input  logic [SRC_W-1:0] pll_src_i,
  input  logic [SRC_N-1:0] en_req_i,
  input  logic [SRC_N-1:0] osc_rdy_i,
  output logic [SRC_N-1:0] osc_en_o,
  output logic [SRC_N-1:0] rdy_o
);
  logic pll_act;
  logic [SRC_N-1:0] keep;

  assign pll_act = (act_i == SRC_PLL);

  for (genvar i = 0; i < SRC_N; i++) begin : g_src
    localparam logic [SRC_W-1:0] CODE = SRC_W'(i);
    if (CODE == SRC_PLL) begin : g_pll
      assign keep[i] = pll_act;
    end else begin : g_osc
      // direct use, or feeding the PLL while the PLL is in use
      assign keep[i] = (act_i == CODE) | (pll_act & (pll_src_i == CODE));
    end
    assign osc_en_o[i] = en_req_i[i] | keep[i];
    assign rdy_o[i]    = osc_rdy_i[i] & osc_en_o[i];
  end
endmodule

// File: rtl/sysclk_sel.sv
module sysclk_sel
  import sysclk_sel_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_we_i,
  input  logic [SRC_W-1:0] req_src_i,
  input  logic [SRC_W-1:0] pll_src_i,
  input  logic [SRC_N-1:0] en_req_i,
  input  logic [SRC_N-1:0] osc_rdy_i,
  output logic [SRC_N-1:0] osc_en_o,
  output logic [SRC_N-1:0] rdy_o,
  output logic [SRC_W-1:0] act_src_o,
  output logic             pend_o
);
  logic             pend_q;
  logic [SRC_W-1:0] tgt_q;
  logic [SRC_W-1:0] act_q;
  logic             commit;

  ssel_pend u_pend (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_we_i  (req_we_i),
    .req_src_i (req_src_i),
    .act_i     (act_q),
    .commit_i  (commit),
    .pend_o    (pend_q),
    .tgt_o     (tgt_q)
  );

  ssel_commit u_commit (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_we_i (req_we_i),
    .pend_i   (pend_q),
    .tgt_i    (tgt_q),
    .rdy_i    (rdy_o),
    .commit_o (commit),
    .act_o    (act_q)
  );

  ssel_keep u_keep (
    .act_i     (act_q),
    .pll_src_i (pll_src_i),
    .en_req_i  (en_req_i),
    .osc_rdy_i (osc_rdy_i),
    .osc_en_o  (osc_en_o),
    .rdy_o     (rdy_o)
  );

  assign act_src_o = act_q;
  assign pend_o    = pend_q;
endmodule

// File: rtl/sysclk_sel_chk.sv
module sysclk_sel_chk
  import sysclk_sel_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_we_i,
  input logic [SRC_W-1:0] req_src_i,
  input logic [SRC_W-1:0] pll_src_i,
  input logic [SRC_N-1:0] osc_en_o,
  input logic [SRC_N-1:0] rdy_o,
  input logic [SRC_W-1:0] act_src_o,
  input logic             pend_o,
  input logic [SRC_W-1:0] tgt_i
);
  logic [SRC_N-1:0] rdy_q;
  logic             pend_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      rdy_q  <= rdy_o;
      pend_q <= pend_o;
    end
  end

  // R2
  commit_on_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_o && rdy_o[tgt_i] && !req_we_i |=> act_src_o == $past(tgt_i) && !pend_o);

  // R3
  hold_not_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_o && !rdy_o[tgt_i] && !req_we_i |=> $stable(act_src_o) && pend_o);

  // R4
  write_replaces_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_we_i && req_src_i != act_src_o |=> pend_o && tgt_i == $past(req_src_i)
                                           && $stable(act_src_o));

  // R5
  same_src_cancel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_we_i && req_src_i == act_src_o |=> !pend_o && $stable(act_src_o));

  // R7
  active_kept_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osc_en_o[act_src_o]);

  // R8
  pll_input_kept_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_src_o == SRC_PLL && pll_src_i != SRC_PLL |-> osc_en_o[pll_src_i]);

  // R11
  switch_only_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(act_src_o) |-> pend_q && rdy_q[act_src_o]);
endmodule

bind sysclk_sel sysclk_sel_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_we_i  (req_we_i),
  .req_src_i (req_src_i),
  .pll_src_i (pll_src_i),
  .osc_en_o  (osc_en_o),
  .rdy_o     (rdy_o),
  .act_src_o (act_src_o),
  .pend_o    (pend_o),
  .tgt_i     (tgt_q)
);

// File: tb/sysclk_sel_bench.sv
module sysclk_sel_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_we_i = 1'b0;
  logic [1:0] req_src_i = '0;
  logic [1:0] pll_src_i = '0;
  logic [3:0] en_req_i = '0;
  logic [3:0] osc_rdy_i = '0;
  logic [3:0] osc_en_o;
  logic [3:0] rdy_o;
  logic [1:0] act_src_o;
  logic       pend_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [1:0] act_m = 2'b00;
  logic       pend_m = 1'b0;
  logic [1:0] tgt_m = 2'b00;

  always #5 clk_i = ~clk_i;

  sysclk_sel u_sysclk_sel (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_we_i  (req_we_i),
    .req_src_i (req_src_i),
    .pll_src_i (pll_src_i),
    .en_req_i  (en_req_i),
    .osc_rdy_i (osc_rdy_i),
    .osc_en_o  (osc_en_o),
    .rdy_o     (rdy_o),
    .act_src_o (act_src_o),
    .pend_o    (pend_o)
  );

  function automatic logic [3:0] exp_en(logic [1:0] act, logic [1:0] psrc, logic [3:0] req);
    logic [3:0] e;
    e = req;
    e[act] = 1'b1;
    if (act == 2'b11 && psrc != 2'b11) e[psrc] = 1'b1;
    return e;
  endfunction

  task automatic check(string tag);
    logic [3:0] en_x;
    logic [3:0] rdy_x;
    en_x  = exp_en(act_m, pll_src_i, en_req_i);
    rdy_x = osc_rdy_i & en_x;
    checks++;
    if (act_src_o !== act_m || pend_o !== pend_m || osc_en_o !== en_x || rdy_o !== rdy_x) begin
      errors++;
      $display("FAIL %s: act=%0d pend=%0d en=%b rdy=%b expected act=%0d pend=%0d en=%b rdy=%b",
               tag, act_src_o, pend_o, osc_en_o, rdy_o, act_m, pend_m, en_x, rdy_x);
    end
  endtask

  task automatic step_model();
    logic [3:0] rdy_x;
    rdy_x = osc_rdy_i & exp_en(act_m, pll_src_i, en_req_i);
    if (req_we_i) begin
      if (req_src_i == act_m) pend_m = 1'b0;
      else begin
        pend_m = 1'b1;
        tgt_m  = req_src_i;
      end
    end else if (pend_m && rdy_x[tgt_m]) begin
      act_m  = tgt_m;
      pend_m = 1'b0;
    end
  endtask

  task automatic cyc(logic we, logic [1:0] src, logic [3:0] en, logic [3:0] rdy,
                     logic [1:0] psrc, string tag);
    @(negedge clk_i);
    req_we_i  = we;
    req_src_i = src;
    en_req_i  = en;
    osc_rdy_i = rdy;
    pll_src_i = psrc;
    #1;
    check(tag);
    @(posedge clk_i);
    step_model();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1c5e_0042));
    #12;
    check("R1 in reset");
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 after release
    cyc(0, 2'b00, 4'b0000, 4'b0000, 2'b11, "R1 after release");
    // R2 ready target commits one edge after write
    cyc(1, 2'b01, 4'b0010, 4'b0011, 2'b11, "R2 write");
    cyc(0, 2'b00, 4'b0010, 4'b0011, 2'b11, "R2 pending");
    cyc(0, 2'b00, 4'b0010, 4'b0011, 2'b11, "R2 committed");
    // R3 not ready, then ready
    cyc(1, 2'b10, 4'b0110, 4'b0010, 2'b11, "R3 write");
    for (int i = 0; i < 4; i++) cyc(0, 2'b00, 4'b0110, 4'b0010, 2'b11, "R3 wait");
    cyc(0, 2'b00, 4'b0110, 4'b0110, 2'b11, "R3 ready rises");
    cyc(0, 2'b00, 4'b0100, 4'b0110, 2'b11, "R3 committed");
    // R7 clear of all enables keeps the active source on
    cyc(0, 2'b00, 4'b0000, 4'b0100, 2'b11, "R7 active kept");
    // R6 ready drops before commit
    cyc(1, 2'b11, 4'b1100, 4'b1100, 2'b10, "R6 write");
    cyc(0, 2'b00, 4'b1100, 4'b0100, 2'b10, "R6 dropped");
    cyc(0, 2'b00, 4'b1100, 4'b0100, 2'b10, "R6 waiting");
    cyc(0, 2'b00, 4'b1100, 4'b1100, 2'b10, "R6 ready back");
    // R8 PLL in use with external input
    cyc(0, 2'b00, 4'b0000, 4'b1100, 2'b10, "R8 input kept");
    cyc(0, 2'b00, 4'b0000, 4'b1101, 2'b00, "R8 multi input kept");
    cyc(0, 2'b00, 4'b0000, 4'b1111, 2'b11, "R8 no input");
    // R4 replace pending target, write beats commit
    cyc(1, 2'b10, 4'b1111, 4'b1001, 2'b10, "R4 first write");
    cyc(1, 2'b01, 4'b1111, 4'b1111, 2'b10, "R4 replace over commit");
    cyc(0, 2'b00, 4'b1110, 4'b1011, 2'b10, "R4 commit new target");
    cyc(0, 2'b00, 4'b1110, 4'b1011, 2'b10, "R4 settled");
    // R5 request of active cancels pending
    cyc(1, 2'b00, 4'b0010, 4'b0010, 2'b11, "R5 pending multi");
    cyc(1, 2'b01, 4'b0010, 4'b0011, 2'b11, "R5 cancel");
    cyc(0, 2'b00, 4'b0010, 4'b0011, 2'b11, "R5 no switch");
    cyc(0, 2'b00, 4'b0010, 4'b0011, 2'b11, "R5 still none");
    // R9 and R10 unprotected enables follow request, ready is masked
    cyc(0, 2'b00, 4'b0101, 4'b1111, 2'b11, "R9 follow");
    cyc(0, 2'b00, 4'b1000, 4'b1111, 2'b11, "R10 masked");
    cyc(0, 2'b00, 4'b0000, 4'b1111, 2'b11, "R9 all off");
    // random mix, R11 commits only on pending and ready
    for (int n = 0; n < 3000; n++) begin
      logic       we;
      logic [1:0] src;
      logic [3:0] en;
      logic [3:0] rdy;
      logic [1:0] ps;
      we  = ($urandom % 6) == 0;
      src = 2'($urandom);
      en  = 4'($urandom);
      rdy = ($urandom % 4 == 0) ? 4'($urandom) : osc_rdy_i;
      ps  = ($urandom % 8 == 0) ? 2'($urandom) : pll_src_i;
      cyc(we, src, en, rdy, ps, "R11 random");
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule